// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers data words from an asynchronous serial line. The line rests high. A frame opens with a low start bit, carries a run of data bits with the least significant bit first, may add a parity bit, and closes with one or two high stop bits. The receiver has no clock of its own at the line rate. It relies on a single-cycle sample strobe that arrives eight times per bit period. It first passes the line through a flop synchroniser, then splits each bit period into eight sub-samples and decides each bit from the three sub-samples around the middle of the period.

Three configuration inputs set the frame shape, and they may change between frames: the word length (5 to 9 bits), the parity mode, and the stop-bit count. Every finished frame produces a one-cycle valid pulse with the received word, and a parity error flag is raised with that pulse when the check fails. A frame whose stop bit is low produces a framing error pulse and no valid pulse. The receiver then stays quiet until the line has returned high.

Top module: `os_uart_rx`

## Requirements
- R1: After reset, `rxValid`, `parityError` and `framingError` are low and `rxData` is zero.
- R2: The receiver leaves its idle state only when it samples the line low, and it takes data bits least significant first. A word of N bits is returned in `rxData[N-1:0]`, and all higher bits of `rxData` are zero.
- R3: `dataBits` sets the word length in bits. Values 5 to 9 are used as given. A value below 5 is treated as 5 and a value above 9 is treated as 9.
- R4: `parityMode` encoding: 2'b00 means no parity bit, 2'b01 means even parity, 2'b10 means odd parity, and 2'b11 means no parity bit. When a parity bit is present, it follows the last data bit.
- R5: When a parity bit is present and the count of ones across the data bits and the parity bit does not match the selected mode (even count for even parity, odd count for odd parity), `parityError` is high in the same cycle as `rxValid`. Otherwise `parityError` stays low.
- R6: With `twoStop` low the frame has one stop bit, and with `twoStop` high it has two. If any expected stop bit is sampled low, `framingError` pulses for one cycle and `rxValid` does not pulse for that frame.
- R7: After a framing error the receiver ignores the line until it is high again. A line that stays low produces no further valid or error pulses.
- R8: If the start bit's middle samples are high, the falling edge is treated as a glitch. The receiver returns to idle and reports nothing.
- R9: Each bit value is the majority of sub-samples 3, 4 and 5 of its eight sub-samples. A disturbance that covers one of them does not change the bit.
- R10: `rxValid` and `framingError` are single-cycle pulses that never occur together. `parityError` is only ever high together with `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle strobe at eight times the bit rate |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| dataBits | input | 4 | Word length in bits (5 to 9, clamped) |
| parityMode | input | 2 | Parity selection, encoded as in R4 |
| twoStop | input | 1 | High selects two stop bits |
| rxData | output | 9 | Received word, right-aligned |
| rxValid | output | 1 | One-cycle pulse when a frame completes |
| parityError | output | 1 | Parity mismatch, valid with `rxValid` |
| framingError | output | 1 | One-cycle pulse for a low stop bit |

## Verification
Several properties are checked on every cycle:
- the output pulses are one cycle wide and relate to each other as R10 states;
- the data bit index stays below the configured length;
- a start is accepted only after a low sample;
- a high start-bit vote sends the controller back to idle;
- the wait state holds while the line is low.

The bench scenarios cover what a property cannot see: the recovered words for each length and parity mode, the clamping of out-of-range lengths, the even/odd parity results, framing on the first and on the second stop bit, recovery after a held-low line, and the majority vote tolerating a short pulse in the middle of a data bit.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;

  localparam int unsigned IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2,
    ST_WAITHI
  } rxState_t;

  typedef enum logic [1:0] {
    PAR_NONE     = 2'b00,
    PAR_EVEN     = 2'b01,
    PAR_ODD      = 2'b10,
    PAR_NONE_ALT = 2'b11
  } parMode_t;

  typedef struct packed {
    logic             sampleEn;
    logic             clearFrame;
    logic             storeData;
    logic [IDX_W-1:0] dataIdx;
    logic             storeParity;
    logic             emitFrame;
    logic             checkParity;
    logic             oddParity;
    logic             flagFraming;
  } rxStrobe_t;

endpackage

// File: rtl/os_uart_rx_sync.sv
module os_uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  // reset to the idle level so no false start appears after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/os_uart_rx_ctrl.sv
module os_uart_rx_ctrl
  import os_uart_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 8,
  parameter int unsigned MIN_BITS   = 5,
  parameter int unsigned MAX_BITS   = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             line,
  input  logic             vote,
  input  logic [IDX_W-1:0] dataBits,
  input  logic [1:0]       parityMode,
  input  logic             twoStop,
  output rxStrobe_t        strobe
);

  localparam int unsigned SUB_W  = $clog2(OVERSAMPLE);
  localparam int unsigned MID    = OVERSAMPLE / 2;
  localparam int unsigned WIN_LO = MID - 1;
  localparam int unsigned WIN_HI = MID + 1;
  localparam int unsigned LAST   = OVERSAMPLE - 1;

  rxState_t         state, nextState;
  logic [SUB_W-1:0] subCnt, nextSub;
  logic [IDX_W-1:0] bitIdx, nextIdx;
  logic [IDX_W-1:0] nBits;
  logic             parityOn;
  logic             bitEnd;
  logic             inFrame;

  always_comb begin
    if (dataBits < IDX_W'(MIN_BITS))      nBits = IDX_W'(MIN_BITS);
    else if (dataBits > IDX_W'(MAX_BITS)) nBits = IDX_W'(MAX_BITS);
    else                                  nBits = dataBits;
  end

  assign parityOn = (parityMode == PAR_EVEN) || (parityMode == PAR_ODD);
  assign bitEnd   = tick && (subCnt == SUB_W'(LAST));
  assign inFrame  = (state != ST_IDLE) && (state != ST_WAITHI);

  always_comb begin
    nextState          = state;
    nextSub            = subCnt;
    nextIdx            = bitIdx;
    strobe             = '0;
    strobe.dataIdx     = bitIdx;
    strobe.checkParity = parityOn;
    strobe.oddParity   = (parityMode == PAR_ODD);
    strobe.sampleEn    = tick && inFrame &&
                         (subCnt >= SUB_W'(WIN_LO)) && (subCnt <= SUB_W'(WIN_HI));

    if (inFrame && tick) nextSub = bitEnd ? '0 : subCnt + 1'b1;

    unique case (state)
      ST_IDLE: begin
        nextSub = '0;
        if (tick && !line) begin
          nextState         = ST_START;
          nextSub           = SUB_W'(1);
          strobe.clearFrame = 1'b1;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          nextIdx   = '0;
          nextState = vote ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          strobe.storeData = 1'b1;
          if (bitIdx == nBits - 1'b1) nextState = parityOn ? ST_PARITY : ST_STOP1;
          else                        nextIdx   = bitIdx + 1'b1;
        end
      end
      ST_PARITY: begin
        if (bitEnd) begin
          strobe.storeParity = 1'b1;
          nextState          = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (bitEnd) begin
          if (!vote) begin
            strobe.flagFraming = 1'b1;
            nextState          = ST_WAITHI;
          end else if (twoStop) begin
            nextState = ST_STOP2;
          end else begin
            strobe.emitFrame = 1'b1;
            nextState        = ST_IDLE;
          end
        end
      end
      ST_STOP2: begin
        if (bitEnd) begin
          if (!vote) begin
            strobe.flagFraming = 1'b1;
            nextState          = ST_WAITHI;
          end else begin
            strobe.emitFrame = 1'b1;
            nextState        = ST_IDLE;
          end
        end
      end
      ST_WAITHI: begin
        nextSub = '0;
        if (line) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      subCnt <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nextState;
      subCnt <= nextSub;
      bitIdx <= nextIdx;
    end
  end

  // R2: a frame is entered only from a low line sample
  assert_low_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && $past(state) == ST_IDLE) |-> !$past(line));

  // R3: the data index never passes the clamped length
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitIdx < nBits));

  // R8: a high start vote abandons the frame
  assert_glitch_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && bitEnd && vote) |=> (state == ST_IDLE));

  // R7: a low line keeps the receiver waiting
  assert_wait_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITHI && !line) |=> (state == ST_WAITHI));

endmodule

// File: rtl/os_uart_rx_dp.sv
module os_uart_rx_dp
  import os_uart_rx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                line,
  input  rxStrobe_t           strobe,
  output logic                vote,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                parityError,
  output logic                framingError
);

  logic [2:0]          votes;
  logic [MAX_BITS-1:0] dataReg;
  logic                parBit;
  logic                parMismatch;

  assign vote = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);

  // even parity expects a zero xor, odd parity expects a one
  assign parMismatch = strobe.checkParity && ((^dataReg ^ parBit) != strobe.oddParity);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      votes   <= '1;
      dataReg <= '0;
      parBit  <= 1'b0;
    end else begin
      if (strobe.sampleEn) votes <= {votes[1:0], line};
      if (strobe.clearFrame) begin
        dataReg <= '0;
        parBit  <= 1'b0;
      end else begin
        if (strobe.storeData)   dataReg[strobe.dataIdx] <= vote;
        if (strobe.storeParity) parBit <= vote;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData       <= '0;
      rxValid      <= 1'b0;
      parityError  <= 1'b0;
      framingError <= 1'b0;
    end else begin
      rxValid      <= strobe.emitFrame;
      framingError <= strobe.flagFraming;
      parityError  <= strobe.emitFrame && parMismatch;
      if (strobe.emitFrame) rxData <= dataReg;
    end
  end

  // R10: output pulse relations
  assert_perr_with_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    parityError |-> rxValid);
  assert_ferr_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    framingError |-> !rxValid);
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  assert_ferr_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    framingError |=> !framingError);

  // R3: stores stay inside the word
  assert_store_index_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeData |-> (strobe.dataIdx < MAX_BITS));

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
  import os_uart_rx_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = 8,
  parameter int unsigned MIN_BITS    = 5,
  parameter int unsigned MAX_BITS    = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleTick,
  input  logic                serialIn,
  input  logic [IDX_W-1:0]    dataBits,
  input  logic [1:0]          parityMode,
  input  logic                twoStop,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxValid,
  output logic                parityError,
  output logic                framingError
);

  logic      lineSync;
  logic      vote;
  rxStrobe_t strobe;

  os_uart_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (serialIn),
    .syncOut (lineSync)
  );

  os_uart_rx_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .MIN_BITS   (MIN_BITS),
    .MAX_BITS   (MAX_BITS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (sampleTick),
    .line       (lineSync),
    .vote       (vote),
    .dataBits   (dataBits),
    .parityMode (parityMode),
    .twoStop    (twoStop),
    .strobe     (strobe)
  );

  os_uart_rx_dp #(.MAX_BITS(MAX_BITS)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .line         (lineSync),
    .strobe       (strobe),
    .vote         (vote),
    .rxData       (rxData),
    .rxValid      (rxValid),
    .parityError  (parityError),
    .framingError (framingError)
  );

endmodule

// File: tb/os_uart_rx_tb_top.sv
module os_uart_rx_tb_top;

  localparam int BIT_CLKS = 32;  // 8 ticks, one every 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       serialIn = 1'b1;
  logic [3:0] dataBits = 4'd8;
  logic [1:0] parityMode = 2'b00;
  logic       twoStop = 1'b0;
  logic [8:0] rxData;
  logic       rxValid, parityError, framingError;

  int testsRun = 0;
  int testsFailed = 0;
  int validCnt = 0;
  int ferrCnt = 0;
  int perrCnt = 0;
  logic [8:0] lastData = '0;

  always #5 clk = ~clk;

  os_uart_rx dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .serialIn(serialIn),
    .dataBits(dataBits), .parityMode(parityMode), .twoStop(twoStop),
    .rxData(rxData), .rxValid(rxValid), .parityError(parityError),
    .framingError(framingError)
  );

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      sampleTick = (cnt == 3);
      cnt = (cnt + 1) % 4;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        validCnt++;
        lastData = rxData;
        if (parityError) perrCnt++;
      end
      if (framingError) ferrCnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic v, input bit glitch);
    for (int c = 0; c < BIT_CLKS; c++) begin
      @(negedge clk);
      serialIn = (glitch && c >= 16 && c < 20) ? ~v : v;
    end
  endtask

  task automatic sendFrame(input logic [8:0] d, input int n, input int pm,
                           input bit badPar, input bit stop1, input bit two,
                           input bit stop2, input int glitchBit, input int holdLow);
    logic p;
    p = ^(d & 9'((1 << n) - 1));
    if (pm == 2) p = ~p;
    if (badPar)  p = ~p;
    driveBit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) driveBit(d[i], i == glitchBit);
    if (pm == 1 || pm == 2) driveBit(p, 1'b0);
    driveBit(stop1, 1'b0);
    if (two) driveBit(stop2, 1'b0);
    for (int h = 0; h < holdLow; h++) driveBit(1'b0, 1'b0);
    driveBit(1'b1, 1'b0);
    driveBit(1'b1, 1'b0);
  endtask

  task automatic expectWord(input string req, input int v0, input int f0, input int p0,
                            input logic [8:0] exp, input bit expPerr);
    chk(validCnt - v0 == 1, {req, " one valid pulse"}, validCnt - v0, 1);
    chk(lastData == exp, {req, " data"}, lastData, exp);
    chk((perrCnt - p0) == int'(expPerr), {req, " parity flag"}, perrCnt - p0, expPerr);
    chk(ferrCnt == f0, {req, " no framing"}, ferrCnt - f0, 0);
  endtask

  task automatic setCfg(input int nb, input int pm, input bit two);
    @(negedge clk);
    dataBits = 4'(nb); parityMode = 2'(pm); twoStop = two;
  endtask

  // R1
  task automatic testReset();
    chk(rxValid == 0 && framingError == 0 && parityError == 0, "R1 flags", 
        {rxValid, framingError, parityError}, 0);
    chk(rxData == 0, "R1 data", rxData, 0);
  endtask

  // R2, R10: basic 8-bit frames, LSB first, single pulse
  task automatic testBasic();
    int v0, f0, p0;
    setCfg(8, 0, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h0A5, 8, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R2 8N1 a5", v0, f0, p0, 9'h0A5, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h031, 8, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R10 8N1 31", v0, f0, p0, 9'h031, 0);
  endtask

  // R3: widths and clamping
  task automatic testWidths();
    int v0, f0, p0;
    setCfg(5, 0, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h1F7, 5, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R3 five bits", v0, f0, p0, 9'h017, 0);
    setCfg(15, 0, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h1A5, 9, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R3 clamp high to nine", v0, f0, p0, 9'h1A5, 0);
    setCfg(2, 0, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h00B, 5, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R3 clamp low to five", v0, f0, p0, 9'h00B, 0);
  endtask

  // R4, R5: parity modes
  task automatic testParity();
    int v0, f0, p0;
    setCfg(8, 1, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h0B3, 8, 1, 0, 1, 0, 1, -1, 0);
    expectWord("R4 even ok", v0, f0, p0, 9'h0B3, 0);
    setCfg(7, 2, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h055, 7, 2, 0, 1, 0, 1, -1, 0);
    expectWord("R4 odd ok", v0, f0, p0, 9'h055, 0);
    setCfg(8, 3, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h0C2, 8, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R4 mode 3 no parity", v0, f0, p0, 9'h0C2, 0);
    setCfg(8, 1, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h0B3, 8, 1, 1, 1, 0, 1, -1, 0);
    expectWord("R5 even mismatch", v0, f0, p0, 9'h0B3, 1);
    setCfg(6, 2, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h02C, 6, 2, 1, 1, 0, 1, -1, 0);
    expectWord("R5 odd mismatch", v0, f0, p0, 9'h02C, 1);
  endtask

  // R6: stop bits
  task automatic testStops();
    int v0, f0, p0;
    setCfg(8, 0, 1);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h0E1, 8, 0, 0, 1, 1, 1, -1, 0);
    expectWord("R6 two stops ok", v0, f0, p0, 9'h0E1, 0);
    v0 = validCnt; f0 = ferrCnt;
    sendFrame(9'h0E1, 8, 0, 0, 1, 1, 0, -1, 0);
    chk(ferrCnt - f0 == 1, "R6 second stop low framing", ferrCnt - f0, 1);
    chk(validCnt == v0, "R6 second stop low no valid", validCnt - v0, 0);
    setCfg(8, 0, 0);
    v0 = validCnt; f0 = ferrCnt;
    sendFrame(9'h07E, 8, 0, 0, 0, 0, 1, -1, 0);
    chk(ferrCnt - f0 == 1, "R6 first stop low framing", ferrCnt - f0, 1);
    chk(validCnt == v0, "R6 first stop low no valid", validCnt - v0, 0);
  endtask

  // R7: held-low line after framing error
  task automatic testHoldLow();
    int v0, f0, p0;
    setCfg(8, 0, 0);
    v0 = validCnt; f0 = ferrCnt;
    sendFrame(9'h000, 8, 0, 0, 0, 0, 1, -1, 3);
    chk(ferrCnt - f0 == 1, "R7 single framing while low", ferrCnt - f0, 1);
    chk(validCnt == v0, "R7 no valid while low", validCnt - v0, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h069, 8, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R7 recovery frame", v0, f0, p0, 9'h069, 0);
  endtask

  // R8: start glitch
  task automatic testGlitch();
    int v0, f0, p0;
    setCfg(8, 0, 0);
    v0 = validCnt; f0 = ferrCnt;
    for (int c = 0; c < 8; c++) begin @(negedge clk); serialIn = 1'b0; end
    for (int c = 0; c < 3 * BIT_CLKS; c++) begin @(negedge clk); serialIn = 1'b1; end
    chk(validCnt == v0 && ferrCnt == f0, "R8 glitch ignored",
        (validCnt - v0) + (ferrCnt - f0), 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h096, 8, 0, 0, 1, 0, 1, -1, 0);
    expectWord("R8 frame after glitch", v0, f0, p0, 9'h096, 0);
  endtask

  // R9: a one-tick disturbance in a data bit's middle is voted out
  task automatic testMajority();
    int v0, f0, p0;
    setCfg(8, 0, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h0F0, 8, 0, 0, 1, 0, 1, 2, 0);
    expectWord("R9 low bit survives pulse", v0, f0, p0, 9'h0F0, 0);
    v0 = validCnt; f0 = ferrCnt; p0 = perrCnt;
    sendFrame(9'h0F0, 8, 0, 0, 1, 0, 1, 5, 0);
    expectWord("R9 high bit survives pulse", v0, f0, p0, 9'h0F0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    testBasic();
    testWidths();
    testParity();
    testStops();
    testHoldLow();
    testGlitch();
    testMajority();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule